// File: doc/BRIEF.md
# Serial Two's-Complement Negator

This block negates a binary word that streams through it one bit per clock, least significant bit first. It keeps a single state bit that remembers whether a 1 has already passed in the current word. While that bit is clear, each incoming bit leaves unchanged. The first 1 is also copied, and it sets the state bit. Every bit after that is inverted. The result is the two's complement of the word, and no adder or word-wide storage is needed.

The output bit is a Mealy function of the present input bit and the state bit. A start-of-word strobe, sampled together with a valid bit, marks that bit as the first of a new word, so back-to-back words are negated independently. Cycles with the valid qualifier low are bubbles: the state holds and the output valid drops. A parameter selects either a combinational output, which has the same-cycle latency of the classic circuit, or a registered output, which adds one cycle and removes the input-to-output timing path.

Top module: `negser_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the seen-a-one flag. With `OUT_REG=1` it also clears `out_vld` and `out_bit`.
- R2: While the flag is clear, each valid bit goes to `out_bit` unchanged. A valid 1 in that state is copied as 1 and sets the flag.
- R3: Once the flag is set, every later valid bit is inverted on `out_bit`. The flag stays set until a reset or a start-of-word strobe.
- R4: When `sow` is high together with `in_vld`, that bit is processed as if the flag were clear. When `sow` is high with `in_vld` low, it is ignored and the flag keeps its value.
- R5: When `in_vld` is low, the flag holds its value and the output stage reports `out_vld`=0 and `out_bit`=0.
- R6: With `OUT_REG=0`, `out_vld` and `out_bit` respond in the same cycle as the input bit. With `OUT_REG=1`, they appear one clock later.
- R7: An N-bit word w sent LSB first with `sow` on its first bit comes out as (2^N - w) mod 2^N, LSB first. For N=8, 0x00 gives 0x00, 0x80 gives 0x80, 0x1C gives 0xE4 and 0x2D gives 0xD3. Bubbles inside the word do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sow | input | 1 | Start-of-word strobe, honoured only with `in_vld` |
| in_bit | input | 1 | Serial input bit, LSB first |
| in_vld | input | 1 | Qualifies `in_bit` |
| out_bit | output | 1 | Serial negated bit; 0 when not valid |
| out_vld | output | 1 | Qualifies `out_bit` |

## Verification
The hardest state to reach from the ports is a flag that is already set when a strobe arrives. The strobe must then override that stale state, while a strobe that arrives without a valid bit must not. The bench sends every 8-bit word back to back with no reset between words, so each word starts right after the previous word's leftover flag. It inserts bubbles in the middle of words and drives a lone strobe during a bubble to separate the two cases.

// File: rtl/negser_pkg.sv
package negser_pkg;

   // One serial symbol: data bit plus its qualifier.
   typedef struct packed {
      logic bit_v;
      logic vld;
   } serbit_t;

   // Mealy output rule: pass while no one seen, invert afterwards.
   function automatic logic neg_bit(input logic din, input logic seen);
      return din ^ seen;
   endfunction

   // Next-state rule: once a one has gone by, stay set.
   function automatic logic next_seen(input logic din, input logic seen);
      return din | seen;
   endfunction

endpackage

// File: rtl/negser_flag.sv
module negser_flag
   import negser_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic adv,
   input  logic clr,
   input  logic din,
   output logic seen_q,
   output logic seen_eff
);

   // A strobe on an accepted bit makes that bit see a clear flag.
   assign seen_eff = (adv && clr) ? 1'b0 : seen_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_q <= 1'b0;
      end else if (adv) begin
         seen_q <= next_seen(din, seen_eff);
      end
   end

endmodule

// File: rtl/negser_xform.sv
module negser_xform
   import negser_pkg::*;
(
   input  logic    din,
   input  logic    vld,
   input  logic    seen,
   output serbit_t q
);

   always_comb begin
      q.vld   = vld;
      q.bit_v = vld & neg_bit(din, seen);
   end

endmodule

// File: rtl/negser_ostage.sv
module negser_ostage
   import negser_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  serbit_t d,
   output serbit_t q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else begin
         q <= d;
      end
   end

endmodule

// File: rtl/negser_top.sv
module negser_top
   import negser_pkg::*;
#(
   parameter int OUT_REG = 0
)(
   input  logic clk,
   input  logic rst,
   input  logic sow,
   input  logic in_bit,
   input  logic in_vld,
   output logic out_bit,
   output logic out_vld
);

   initial begin
      assert (OUT_REG == 0 || OUT_REG == 1)
         else $error("negser_top: OUT_REG must be 0 or 1");
   end

   logic    seen_q;
   logic    seen_eff;
   serbit_t mid;
   serbit_t fin;

   negser_flag u_flag (
      .clk      (clk),
      .rst      (rst),
      .adv      (in_vld),
      .clr      (sow),
      .din      (in_bit),
      .seen_q   (seen_q),
      .seen_eff (seen_eff)
   );

   negser_xform u_xf (
      .din  (in_bit),
      .vld  (in_vld),
      .seen (seen_eff),
      .q    (mid)
   );

   generate
      if (OUT_REG == 1) begin : g_reg
         negser_ostage u_os (
            .clk (clk),
            .rst (rst),
            .d   (mid),
            .q   (fin)
         );
      end else begin : g_comb
         assign fin = mid;
      end
   endgenerate

   assign out_bit = fin.bit_v;
   assign out_vld = fin.vld;

endmodule

// File: rtl/negser_chk.sv
module negser_chk #(
   parameter int OUT_REG = 0
)(
   input logic clk,
   input logic rst,
   input logic sow,
   input logic in_bit,
   input logic in_vld,
   input logic out_bit,
   input logic out_vld,
   input logic seen_q
);

   // R1
   reset_clear_chk: assert property (@(posedge clk) rst |=> !seen_q);

   // R3
   sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (seen_q && !(in_vld && sow)) |=> seen_q);

   // R5
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> $stable(seen_q));

   generate
      if (OUT_REG == 1) begin : g_reg
         // R1
         reset_out_chk: assert property (@(posedge clk) rst |=> !out_vld);
         // R2
         copy_chk: assert property (@(posedge clk) disable iff (rst)
            (in_vld && !sow && !seen_q) |=> (out_bit == $past(in_bit)));
         // R3
         invert_chk: assert property (@(posedge clk) disable iff (rst)
            (in_vld && !sow && seen_q) |=> (out_bit == !$past(in_bit)));
         // R4
         sow_chk: assert property (@(posedge clk) disable iff (rst)
            (in_vld && sow) |=> (out_bit == $past(in_bit)));
         // R5
         quiet_chk: assert property (@(posedge clk) disable iff (rst)
            !in_vld |=> (!out_vld && !out_bit));
         // R6
         lag_chk: assert property (@(posedge clk) disable iff (rst)
            in_vld |=> out_vld);
      end else begin : g_comb
         // R2
         copy_chk: assert property (@(posedge clk) disable iff (rst)
            (in_vld && !sow && !seen_q) |-> (out_bit == in_bit));
         // R3
         invert_chk: assert property (@(posedge clk) disable iff (rst)
            (in_vld && !sow && seen_q) |-> (out_bit == !in_bit));
         // R4
         sow_chk: assert property (@(posedge clk) disable iff (rst)
            (in_vld && sow) |-> (out_bit == in_bit));
         // R5
         quiet_chk: assert property (@(posedge clk) disable iff (rst)
            !in_vld |-> (!out_vld && !out_bit));
      end
   endgenerate

endmodule

bind negser_top negser_chk #(.OUT_REG(OUT_REG)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .sow     (sow),
   .in_bit  (in_bit),
   .in_vld  (in_vld),
   .out_bit (out_bit),
   .out_vld (out_vld),
   .seen_q  (seen_q)
);

// File: tb/negser_top_bench.sv
`timescale 1ns/1ps
module negser_top_bench;

   localparam int W = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sow = 1'b0;
   logic in_bit = 1'b0;
   logic in_vld = 1'b0;
   logic ob0, ov0, ob1, ov1;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [W-1:0] acc0, acc1;
   int n0, n1;

   always #2 clk = ~clk;

   negser_top #(.OUT_REG(0)) u_negser_top (
      .clk(clk), .rst(rst), .sow(sow), .in_bit(in_bit), .in_vld(in_vld),
      .out_bit(ob0), .out_vld(ov0)
   );

   negser_top #(.OUT_REG(1)) u_negser_top_r (
      .clk(clk), .rst(rst), .sow(sow), .in_bit(in_bit), .in_vld(in_vld),
      .out_bit(ob1), .out_vld(ov1)
   );

   // Collect output streams of both variants.
   always @(negedge clk) begin
      if (ov0) begin
         acc0 <= {ob0, acc0[W-1:1]};
         n0   <= n0 + 1;
      end
      if (ov1) begin
         acc1 <= {ob1, acc1[W-1:1]};
         n1   <= n1 + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic b, input logic s, input logic v);
      @(posedge clk);
      #1;
      in_bit = b;
      sow    = s;
      in_vld = v;
   endtask

   // Idle cycle; checks the bubble behaviour of the same-cycle variant.
   task automatic bubble(input logic s);
      drive(1'b0, s, 1'b0);
      @(negedge clk);
      chk(!ov0 && !ob0, "R5 bubble quiet", {ov0, ob0}, 0);
   endtask

   task automatic send_word(input logic [W-1:0] w, input int gap_at);
      logic [W-1:0] exp;
      exp = W'(0) - w;
      @(posedge clk);
      #1;
      acc0 = '0; acc1 = '0; n0 = 0; n1 = 0;
      for (int i = 0; i < W; i++) begin
         if (i == gap_at) bubble(1'b0);
         drive(w[i], (i == 0), 1'b1);
      end
      drive(1'b0, 1'b0, 1'b0);
      @(posedge clk);
      @(posedge clk);
      #1;
      chk(n0 == W && acc0 == exp, "R7 word comb", int'(acc0), int'(exp));
      chk(n1 == W && acc1 == exp, "R7 word reg", int'(acc1), int'(exp));
   endtask

   initial begin
      #400000;
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      acc0 = '0; acc1 = '0; n0 = 0; n1 = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(!ov0 && !ov1 && !ob1, "R1 reset outputs", {ov0, ov1, ob1}, 0);
      #1;
      rst = 1'b0;

      // R2 / R3 bit-level behaviour with a strobe on the first bit
      drive(1'b0, 1'b1, 1'b1); @(negedge clk);
      chk(ob0 == 1'b0 && ov0, "R2 copy zero", ob0, 0);
      drive(1'b1, 1'b0, 1'b1); @(negedge clk);
      chk(ob0 == 1'b1, "R2 first one copied", ob0, 1);
      drive(1'b1, 1'b0, 1'b1); @(negedge clk);
      chk(ob0 == 1'b0, "R3 one inverted", ob0, 0);
      drive(1'b0, 1'b0, 1'b1); @(negedge clk);
      chk(ob0 == 1'b1, "R3 zero inverted", ob0, 1);

      // R5: bubble with a lone strobe keeps the flag set (R4 ignored strobe)
      bubble(1'b1);
      drive(1'b0, 1'b0, 1'b1); @(negedge clk);
      chk(ob0 == 1'b1, "R4 strobe without valid ignored", ob0, 1);

      // R4: strobe with valid clears the stale flag for this bit
      drive(1'b1, 1'b1, 1'b1); @(negedge clk);
      chk(ob0 == 1'b1, "R4 strobe clears flag", ob0, 1);

      // R1: reset clears a set flag
      drive(1'b0, 1'b0, 1'b0);
      @(posedge clk); #1; rst = 1'b1;
      @(posedge clk); #1; rst = 1'b0;
      drive(1'b0, 1'b0, 1'b1); @(negedge clk);
      chk(ob0 == 1'b0, "R1 flag cleared by reset", ob0, 0);

      // R6: latency of both variants after an idle cycle
      drive(1'b0, 1'b0, 1'b0);
      drive(1'b1, 1'b1, 1'b1); @(negedge clk);
      chk(ov0 && !ov1, "R6 same-cycle vs lagged valid", {ov0, ov1}, 2);
      drive(1'b0, 1'b0, 1'b0); @(negedge clk);
      chk(!ov0 && ov1 && ob1, "R6 lagged bit appears", {ov0, ov1, ob1}, 3);

      // R7: named corner words
      send_word(8'h00, -1);
      send_word(8'h80, -1);
      send_word(8'h1C, 3);
      send_word(8'h2D, 5);
      send_word(8'hFF, -1);
      send_word(8'h01, 1);

      // R7: exhaustive sweep, back to back, bubbles in some words
      for (int w = 0; w < (1 << W); w++) begin
         send_word(W'(w), (w % 5 == 0) ? (w % W) : -1);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule